// File: doc/BRIEF.md
# Retained Pad Pull Enable Bank

This block is an APB slave that holds the pull-up and pull-down enables for a 16-pin GPIO port. Software writes one enable bit per pin into each of two 32-bit registers. The block turns the stored bits into a final pull-up enable and a final pull-down enable for every pad.

The stored bits reach the pads only while both processors' apply-pull flags are high. If a pin has both of its bits set, the pull-down wins and the pull-up is suppressed.

Register accesses are deliberately slow. A write stalls for a fixed number of extra APB cycles and a read stalls for a smaller fixed number. The block has two resets. The full power-on reset clears the stored enables. The standby-exit reset clears only the access sequencing and leaves the stored enables untouched, so pad pulls stay in force while the rest of the chip wakes up.

Top module: `pull_ctrl_bank`

## Requirements
- R1: Asserting `por_rst` for one clock clears both stored enable words to zero. Both then read back as 0x0000_0000, and `pu_en`/`pd_en` are all zero.
- R2: Bits 31:16 of both registers always read as zero. Writing ones to those bits changes nothing that can be read back.
- R3: Offset 0x028 holds the pull-up enables and offset 0x02C holds the pull-down enables. Bit y of each register, for y from 0 to 15, belongs to pad y. A completed write to either offset can be read back from bits 15:0 of that offset.
- R4: `pu_en[y]` and `pd_en[y]` are high only when the stored bit is set and both `apply_a` and `apply_b` are high. The outputs follow the flags combinationally, in the same cycle.
- R5: When both stored bits of pad y are set and the outputs are applied, `pd_en[y]` is 1 and `pu_en[y]` is 0.
- R6: A write to 0x028 or 0x02C holds `pready` low for exactly 3 access-phase cycles and drives it high in the 4th. The data is committed on that clock edge.
- R7: A read of 0x028 or 0x02C holds `pready` low for exactly 2 access-phase cycles. `prdata` is valid in the cycle `pready` is high.
- R8: An access to any other offset completes in its first access cycle and reads as zero. Writes to such an offset leave both registers unchanged. `pslverr` stays low for every access.
- R9: Pulsing `sby_rst` while `por_rst` is low leaves both stored enable words and the pad outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| por_rst | input | 1 | Synchronous active-high full power-on reset |
| sby_rst | input | 1 | Synchronous active-high standby-exit reset; clears only the access logic |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, low during wait states |
| pslverr | output | 1 | APB error, always low |
| apply_a | input | 1 | Apply-pull flag from the first processor |
| apply_b | input | 1 | Apply-pull flag from the second processor |
| pu_en | output | 16 | Per-pad pull-up enables |
| pd_en | output | 16 | Per-pad pull-down enables |

## Verification
A register write that completes and a change in the apply flags can land on the same clock edge. The new stored bits and the new flag level then reach the pad enables together. The bench provokes this by raising `apply_b` in the final access cycle of a pull-up write. In the following cycle it compares `pu_en`/`pd_en` against a resolution computed from the new word and the new flags, so a stale value of either input shows up as a mismatch. The scoreboard also compares the counted wait cycles of every transfer against 3 or 2.

// File: rtl/pcb_pkg.sv
`timescale 1ns/1ps
package pcb_pkg;
  // which retained register an address selects
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_UP   = 2'd1,
    SEL_DN   = 2'd2
  } reg_sel_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pcb_apb_wait.sv
`timescale 1ns/1ps
// Wait-state generator: loads a down-counter in the setup phase and holds
// ready low while the counter is non-zero during the access phase.
module pcb_apb_wait #(
  parameter int unsigned WR_WAIT = 3,
  parameter int unsigned RD_WAIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic psel,
  input  logic penable,
  input  logic pwrite,
  input  logic hit,
  output logic ready
);
  localparam int unsigned MAXW  = pcb_pkg::max_u(WR_WAIT, RD_WAIT);
  localparam int unsigned CNT_W = (MAXW < 1) ? 1 : $clog2(MAXW + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  logic             setup_ph;
  logic             access_ph;

  assign setup_ph  = psel & ~penable;
  assign access_ph = psel & penable;

  always_comb begin
    if (!hit)        load_val = '0;
    else if (pwrite) load_val = CNT_W'(WR_WAIT);
    else             load_val = CNT_W'(RD_WAIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (setup_ph) begin
      cnt_q <= load_val;
    end else if (access_ph && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ready = (cnt_q == '0);
endmodule

// File: rtl/pcb_regs.sv
`timescale 1ns/1ps
// Retained enable storage: cleared only by the power-on reset.
module pcb_regs #(
  parameter int unsigned NPIN = 16
) (
  input  logic            clk,
  input  logic            por_rst,
  input  logic            we_up,
  input  logic            we_dn,
  input  logic [NPIN-1:0] wdata,
  output logic [NPIN-1:0] up_q,
  output logic [NPIN-1:0] dn_q
);
  always_ff @(posedge clk) begin
    if (por_rst) begin
      up_q <= '0;
    end else if (we_up) begin
      up_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (por_rst) begin
      dn_q <= '0;
    end else if (we_dn) begin
      dn_q <= wdata;
    end
  end
endmodule

// File: rtl/pcb_resolve.sv
`timescale 1ns/1ps
// Per-pad resolution: gate by both apply flags, pull-down wins on conflict.
module pcb_resolve #(
  parameter int unsigned NPIN = 16
) (
  input  logic            apply_a,
  input  logic            apply_b,
  input  logic [NPIN-1:0] up_q,
  input  logic [NPIN-1:0] dn_q,
  output logic [NPIN-1:0] pu_en,
  output logic [NPIN-1:0] pd_en
);
  logic gate;
  assign gate = apply_a & apply_b;

  for (genvar y = 0; y < NPIN; y++) begin : g_pad
    assign pd_en[y] = gate & dn_q[y];
    assign pu_en[y] = gate & up_q[y] & ~dn_q[y];
  end
endmodule

// File: rtl/pull_ctrl_bank.sv
`timescale 1ns/1ps
module pull_ctrl_bank #(
  parameter int unsigned         NPIN    = 16,
  parameter int unsigned         DATA_W  = 32,
  parameter int unsigned         ADDR_W  = 12,
  parameter int unsigned         WR_WAIT = 3,
  parameter int unsigned         RD_WAIT = 2,
  parameter logic [ADDR_W-1:0]   UP_OFS  = 12'h028,
  parameter logic [ADDR_W-1:0]   DN_OFS  = 12'h02C
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              sby_rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              apply_a,
  input  logic              apply_b,
  output logic [NPIN-1:0]   pu_en,
  output logic [NPIN-1:0]   pd_en
);
  import pcb_pkg::*;

  localparam int unsigned WORD_LSB = 2;
  localparam int unsigned RSV_W    = DATA_W - NPIN;

  reg_sel_e        sel;
  logic            hit;
  logic            commit;
  logic [NPIN-1:0] up_q;
  logic [NPIN-1:0] dn_q;
  logic [NPIN-1:0] rd_word;
  logic            unused_bits;

  // word-aligned address decode
  always_comb begin
    if (paddr[ADDR_W-1:WORD_LSB] == UP_OFS[ADDR_W-1:WORD_LSB])      sel = SEL_UP;
    else if (paddr[ADDR_W-1:WORD_LSB] == DN_OFS[ADDR_W-1:WORD_LSB]) sel = SEL_DN;
    else                                                          sel = SEL_NONE;
  end
  assign hit = (sel != SEL_NONE);

  pcb_apb_wait #(
    .WR_WAIT(WR_WAIT),
    .RD_WAIT(RD_WAIT)
  ) wait_i (
    .clk    (clk),
    .rst    (por_rst | sby_rst),
    .psel   (psel),
    .penable(penable),
    .pwrite (pwrite),
    .hit    (hit),
    .ready  (pready)
  );

  assign commit = psel & penable & pwrite & pready;

  pcb_regs #(.NPIN(NPIN)) regs_i (
    .clk    (clk),
    .por_rst(por_rst),
    .we_up  (commit && sel == SEL_UP),
    .we_dn  (commit && sel == SEL_DN),
    .wdata  (pwdata[NPIN-1:0]),
    .up_q   (up_q),
    .dn_q   (dn_q)
  );

  always_comb begin
    unique case (sel)
      SEL_UP:  rd_word = up_q;
      SEL_DN:  rd_word = dn_q;
      default: rd_word = '0;
    endcase
  end

  // reserved upper bits read as zero
  assign prdata  = {{RSV_W{1'b0}}, rd_word};
  assign pslverr = 1'b0;

  pcb_resolve #(.NPIN(NPIN)) resolve_i (
    .apply_a(apply_a),
    .apply_b(apply_b),
    .up_q   (up_q),
    .dn_q   (dn_q),
    .pu_en  (pu_en),
    .pd_en  (pd_en)
  );

  assign unused_bits = ^{pwdata[DATA_W-1:NPIN], paddr[WORD_LSB-1:0]};
endmodule

// File: rtl/pcb_chk.sv
`timescale 1ns/1ps
module pcb_chk #(
  parameter int unsigned       NPIN    = 16,
  parameter int unsigned       DATA_W  = 32,
  parameter int unsigned       ADDR_W  = 12,
  parameter int unsigned       WR_WAIT = 3,
  parameter int unsigned       RD_WAIT = 2,
  parameter logic [ADDR_W-1:0] UP_OFS  = 12'h028,
  parameter logic [ADDR_W-1:0] DN_OFS  = 12'h02C
) (
  input logic              clk,
  input logic              por_rst,
  input logic              sby_rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] prdata,
  input logic              pready,
  input logic              apply_a,
  input logic              apply_b,
  input logic [NPIN-1:0]   pu_en,
  input logic [NPIN-1:0]   pd_en,
  input logic [NPIN-1:0]   up_q,
  input logic [NPIN-1:0]   dn_q
);
  logic [7:0] acc_cnt;
  logic       clean;
  logic       hit;
  logic       done;

  assign hit  = (paddr[ADDR_W-1:2] == UP_OFS[ADDR_W-1:2]) ||
                (paddr[ADDR_W-1:2] == DN_OFS[ADDR_W-1:2]);
  assign done = psel && penable && pready;

  // independent count of stalled access cycles of the current transfer
  always_ff @(posedge clk) begin
    if (por_rst) begin
      acc_cnt <= '0;
      clean   <= 1'b0;
    end else begin
      if (psel && !penable) begin
        acc_cnt <= '0;
        clean   <= !sby_rst;
      end else if (psel && penable && !pready) begin
        acc_cnt <= acc_cnt + 8'd1;
        if (sby_rst) clean <= 1'b0;
      end else if (sby_rst) begin
        clean <= 1'b0;
      end
    end
  end

  // R1
  a_r1_por_clears: assert property (@(posedge clk)
    por_rst |=> (up_q == '0 && dn_q == '0));

  a_r2_rsv_zero: assert property (@(posedge clk) disable iff (por_rst)
    (done && !pwrite) |-> (prdata[DATA_W-1:NPIN] == '0));

  a_r4_gate: assert property (@(posedge clk) disable iff (por_rst)
    !(apply_a && apply_b) |-> (pu_en == '0 && pd_en == '0));

  a_r5_dn_wins: assert property (@(posedge clk) disable iff (por_rst)
    ((pu_en & pd_en) == '0));

  a_r6_wr_wait: assert property (@(posedge clk) disable iff (por_rst || sby_rst)
    (done && pwrite && hit && clean) |-> (acc_cnt == 8'(WR_WAIT)));

  a_r7_rd_wait: assert property (@(posedge clk) disable iff (por_rst || sby_rst)
    (done && !pwrite && hit && clean) |-> (acc_cnt == 8'(RD_WAIT)));

  a_r8_miss_fast: assert property (@(posedge clk) disable iff (por_rst || sby_rst)
    (psel && penable && !hit) |-> (pready && prdata == '0));

  a_r9_retain: assert property (@(posedge clk) disable iff (por_rst)
    (sby_rst && !(done && pwrite)) |=> ($stable(up_q) && $stable(dn_q)));
endmodule

bind pull_ctrl_bank pcb_chk #(
  .NPIN(NPIN), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .WR_WAIT(WR_WAIT), .RD_WAIT(RD_WAIT), .UP_OFS(UP_OFS), .DN_OFS(DN_OFS)
) chk_i (
  .clk(clk), .por_rst(por_rst), .sby_rst(sby_rst), .psel(psel),
  .penable(penable), .pwrite(pwrite), .paddr(paddr), .prdata(prdata),
  .pready(pready), .apply_a(apply_a), .apply_b(apply_b),
  .pu_en(pu_en), .pd_en(pd_en), .up_q(up_q), .dn_q(dn_q)
);

// File: tb/pull_ctrl_bank_tb_top.sv
`timescale 1ns/1ps
module pull_ctrl_bank_tb_top;
  logic        clk = 1'b0;
  logic        por_rst = 1'b1;
  logic        sby_rst = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic        pslverr;
  logic        apply_a = 1'b0;
  logic        apply_b = 1'b0;
  logic [15:0] pu_en;
  logic [15:0] pd_en;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // scoreboard queues
  bit          q_wr[$];
  logic [31:0] q_data[$];
  int          q_wait[$];
  string       q_tag[$];

  pull_ctrl_bank dut_i (
    .clk(clk), .por_rst(por_rst), .sby_rst(sby_rst), .psel(psel),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .apply_a(apply_a), .apply_b(apply_b), .pu_en(pu_en), .pd_en(pd_en)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per completed transfer
  int acc = 0;
  always @(negedge clk) begin
    if (psel && penable) begin
      if (!pready) begin
        acc++;
      end else begin
        if (q_wr.size() == 0) begin
          check(1'b0, "scoreboard-empty", 32'(acc), 32'hFFFF_FFFF);
        end else begin
          automatic bit          w = q_wr.pop_front();
          automatic logic [31:0] d = q_data.pop_front();
          automatic int          k = q_wait.pop_front();
          automatic string       t = q_tag.pop_front();
          check(acc == k, {t, " wait count"}, 32'(acc), 32'(k));
          check(pslverr == 1'b0, "R8 pslverr", 32'(pslverr), 32'd0);
          if (!w) check(prdata === d, {t, " read data"}, prdata, d);
        end
        acc = 0;
      end
    end
  end

  task automatic apb(input bit wr, input logic [11:0] a, input logic [31:0] wd,
                     input logic [31:0] exp_rd, input int waits,
                     input string tag, input bit raise_b);
    q_wr.push_back(wr);
    q_data.push_back(exp_rd);
    q_wait.push_back(waits);
    q_tag.push_back(tag);
    @(posedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd;
    @(posedge clk); #1;
    penable = 1'b1;
    forever begin
      @(negedge clk);
      if (pready) break;
    end
    if (raise_b) apply_b = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  function automatic logic [31:0] res_up(input logic [15:0] u, input logic [15:0] d, input bit g);
    return g ? {16'h0, u & ~d} : 32'h0;
  endfunction
  function automatic logic [31:0] res_dn(input logic [15:0] d, input bit g);
    return g ? {16'h0, d} : 32'h0;
  endfunction

  task automatic check_pads(input logic [15:0] u, input logic [15:0] d, input string tag);
    automatic bit g = apply_a & apply_b;
    @(negedge clk);
    check({16'h0, pu_en} == res_up(u, d, g), {tag, " pu_en"}, {16'h0, pu_en}, res_up(u, d, g));
    check({16'h0, pd_en} == res_dn(d, g),    {tag, " pd_en"}, {16'h0, pd_en}, res_dn(d, g));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 por_rst = 1'b0;
    apply_a = 1'b1; apply_b = 1'b1;
    // R1 reset state
    check_pads(16'h0, 16'h0, "R1 reset");
    apb(0, 12'h028, '0, 32'h0, 2, "R1/R7 up after por", 0);
    apb(0, 12'h02C, '0, 32'h0, 2, "R1/R7 dn after por", 0);

    // R2, R3, R6: writes with reserved bits set
    apb(1, 12'h028, 32'hFFFF_A5C3, '0, 3, "R6 write up", 0);
    apb(1, 12'h02C, 32'h1234_0F0F, '0, 3, "R6 write dn", 0);
    apb(0, 12'h028, '0, 32'h0000_A5C3, 2, "R2/R3 read up", 0);
    apb(0, 12'h02C, '0, 32'h0000_0F0F, 2, "R2/R3 read dn", 0);

    // R4, R5: all four flag combinations, conflict pads 0x0503
    for (int c = 0; c < 4; c++) begin
      @(posedge clk); #1;
      apply_a = c[0]; apply_b = c[1];
      check_pads(16'hA5C3, 16'h0F0F, "R4/R5 flags");
    end

    // R8: other offsets
    apb(0, 12'h030, '0, 32'h0, 0, "R8 miss read", 0);
    apb(1, 12'h034, 32'hFFFF_FFFF, '0, 0, "R8 miss write", 0);
    apb(0, 12'h028, '0, 32'h0000_A5C3, 2, "R8 up unchanged", 0);
    apb(0, 12'h02C, '0, 32'h0000_0F0F, 2, "R8 dn unchanged", 0);

    // R9: standby reset keeps contents and outputs
    @(posedge clk); #1;
    apply_a = 1'b1; apply_b = 1'b1;
    sby_rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 sby_rst = 1'b0;
    check_pads(16'hA5C3, 16'h0F0F, "R9 pads after standby");
    apb(0, 12'h028, '0, 32'h0000_A5C3, 2, "R9 up retained", 0);
    apb(0, 12'h02C, '0, 32'h0000_0F0F, 2, "R9 dn retained", 0);

    // R4/R6: commit and flag rise on the same edge
    @(posedge clk); #1;
    apply_b = 1'b0;
    apb(1, 12'h028, 32'h0000_F0F0, '0, 3, "R6 write with flag", 1);
    check_pads(16'hF0F0, 16'h0F0F, "R4 same-edge commit");

    // R1 again: power-on reset clears
    @(posedge clk); #1 por_rst = 1'b1;
    @(posedge clk); #1 por_rst = 1'b0;
    check_pads(16'h0, 16'h0, "R1 second por");
    apb(0, 12'h028, '0, 32'h0, 2, "R1 up cleared", 0);
    apb(0, 12'h02C, '0, 32'h0, 2, "R1 dn cleared", 0);

    repeat (3) @(posedge clk);
    check(q_wr.size() == 0, "scoreboard drained", 32'(q_wr.size()), 32'd0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      check(1'b0, "watchdog", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule